// File: doc/BRIEF.md
# Serial Bus Master Register Front-End

This block is the host-facing control and status layer of a two-wire serial bus master. A host reaches it through a plain 32-bit register write port and a combinational read port. The host loads a command code, a target register index, write data and a device address, then sets a start bit. The block hands these values to a separate wire engine, holds the start bit set while the engine works, and records the outcome in write-one-to-clear status bits. A single interrupt line summarises that status.

The block also provides several other controls. A one-cycle self-clearing soft reset returns every register to its reset value. An abort cancels a running transfer, and a device-init trigger clears itself when the engine reports the init sequence is finished. Direct override controls drive the clock and data lines and read back their levels. Two fields set the bus clock divider and the data output delay. When a read command ends, the returned word is cut down to the byte width that the command code implies.

Top module: `sbm_regfront`

## Requirements
- R1: After reset every register reads 0 and `irq`, `eng_start`, `eng_abort` and `init_start` are low. Register offsets: 0x00 control, 0x04 clock control, 0x08 interrupt enable, 0x0C status, 0x10 register index, 0x1C data, 0x24 line control, 0x28 device-mode, 0x2C command, 0x30 device address.
- R2: Writing control bit 7 while idle gives a one-cycle `eng_start` pulse. Control bit 7 then reads 1 until the cycle after `eng_done`.
- R3: On `eng_done` the block sets status bit 0 (done). If `eng_err_nack` is high it also sets status bit 1 (error) and status bit 16. If `eng_err_data` is nonzero it sets status bit 1 and ORs `eng_err_data` into status bits 11:8.
- R4: Read commands are 0x8B (1 byte), 0x9C (2 bytes) and 0xA6 (4 bytes). On an error-free completion of one of these, the data register takes `eng_rdata` with the bytes above the width forced to 0. Any other command leaves the data register unchanged, and so does a completion with an error.
- R5: While control bit 7 is set, a write to the command, register-index or data register is ignored and sets status bit 2 (load-busy).
- R6: Writing 1 to a status bit clears it and writing 0 leaves it. An event in the same cycle wins over the clear.
- R7: `irq` is control bit 1 (global enable) ANDed with the OR of status bits 2:0 each masked by the same bit of the interrupt-enable register.
- R8: Writing control bit 6 while busy gives a one-cycle `eng_abort` pulse and clears control bit 7 without setting any status bit.
- R9: Writing control bit 0 makes bit 0 read 1 for exactly one cycle. It returns all other registers and the status to their reset values.
- R10: Writing device-mode bit 31 gives a one-cycle `init_start` pulse. Bit 31 reads 1 until the cycle after `init_done`. Bits 30:0 are stored as written.
- R11: Line-control bits 3:0 drive `scl_ovr_val`, `scl_ovr_en`, `sda_ovr_val` and `sda_ovr_en` in that order from bit 3 down. Bits 5 and 4 read `scl_in` and `sda_in`.
- R12: Clock-control bits 7:0 drive `bus_div` and bits 10:8 drive `bus_sda_dly`. Device-address bits 23:16 drive `eng_rtaddr` and bits 15:0 drive `eng_hwaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr` |
| eng_start | output | 1 | One-cycle start pulse to the wire engine |
| eng_abort | output | 1 | One-cycle abort pulse to the wire engine |
| eng_cmd | output | 8 | Command code |
| eng_regaddr | output | 8 | Target register index |
| eng_wdata | output | 32 | Data register contents |
| eng_rtaddr | output | 8 | Runtime address |
| eng_hwaddr | output | 16 | Device hardware address |
| eng_done | input | 1 | Transfer finished |
| eng_rdata | input | 32 | Word returned by a read |
| eng_err_nack | input | 1 | Missing acknowledge, valid with `eng_done` |
| eng_err_data | input | 4 | Per-byte parity errors, valid with `eng_done` |
| init_start | output | 1 | One-cycle device-init pulse |
| init_done | input | 1 | Device-init sequence finished |
| bus_div | output | 8 | Clock divider |
| bus_sda_dly | output | 3 | Data output delay |
| scl_ovr_en | output | 1 | Clock line override enable |
| scl_ovr_val | output | 1 | Clock line override level |
| sda_ovr_en | output | 1 | Data line override enable |
| sda_ovr_val | output | 1 | Data line override level |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| irq | output | 1 | Interrupt |

## Verification
The bench runs every command code through a full transfer with the same returned word. A wrong byte mask would show up as leaked upper bytes in the data register. Loading a register while busy must leave it unchanged and raise load-busy; a design that accepted the load would show the new command value on readback. The interrupt is swept over all enable masks with global enable on and off, and then the status bits are cleared one at a time, which exposes a wrong mask bit or a clear that touches its neighbours. A completed read that carries an error must not update the data register. The soft-reset bit must read 1 for exactly one cycle.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    localparam int unsigned WORD_W = 32;

    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_CLK  = 'h04;
    localparam int unsigned OFS_INTE = 'h08;
    localparam int unsigned OFS_STAT = 'h0C;
    localparam int unsigned OFS_RIDX = 'h10;
    localparam int unsigned OFS_DATA = 'h1C;
    localparam int unsigned OFS_LINE = 'h24;
    localparam int unsigned OFS_DMOD = 'h28;
    localparam int unsigned OFS_CMD  = 'h2C;
    localparam int unsigned OFS_DADR = 'h30;

    localparam logic [7:0] CMD_RD1 = 8'h8B;
    localparam logic [7:0] CMD_RD2 = 8'h9C;
    localparam logic [7:0] CMD_RD4 = 8'hA6;

    localparam int unsigned CB_SRST  = 0;
    localparam int unsigned CB_GIE   = 1;
    localparam int unsigned CB_ABORT = 6;
    localparam int unsigned CB_START = 7;
    localparam int unsigned DM_GO    = 31;

    typedef struct packed {
        logic        srst;
        logic        busy;
        logic        gie;
        logic        start_p;
        logic        abort_p;
        logic        init_p;
        logic [10:0] clkctl;
        logic [2:0]  inte;
        logic [7:0]  ridx;
        logic [31:0] data;
        logic [3:0]  line;
        logic [31:0] dmod;
        logic [7:0]  cmd;
        logic [23:0] dadr;
    } front_t;

    typedef struct packed {
        logic       nack;
        logic [3:0] derr;
        logic       lbsy;
        logic       err;
        logic       done;
    } stat_t;
endpackage

// File: rtl/sbm_width_mask.sv
module sbm_width_mask
    import sbm_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic [7:0]    cmd,
    input  logic [DW-1:0] raw,
    output logic          is_read,
    output logic [DW-1:0] masked
);
    localparam int unsigned NB = DW / 8;
    localparam int unsigned CW = $clog2(NB + 1);

    logic [CW-1:0] nbytes;

    always_comb begin
        is_read = 1'b1;
        nbytes  = CW'(NB);
        unique case (cmd)
            CMD_RD1: nbytes = CW'(1);
            CMD_RD2: nbytes = CW'(2);
            CMD_RD4: nbytes = CW'(4);
            default: is_read = 1'b0;
        endcase
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign masked[8*b +: 8] = (CW'(b) < nbytes) ? raw[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/sbm_status_unit.sv
module sbm_status_unit
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ev_done,
    input  logic              ev_nack,
    input  logic [3:0]        ev_derr,
    input  logic              ev_lbsy,
    input  logic [2:0]        inte,
    input  logic              gie,
    output logic [WORD_W-1:0] status_word,
    output logic              irq
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.done = st_q.done & ~wdata[0];
            st_d.err  = st_q.err  & ~wdata[1];
            st_d.lbsy = st_q.lbsy & ~wdata[2];
            st_d.derr = st_q.derr & ~wdata[11:8];
            st_d.nack = st_q.nack & ~wdata[16];
        end
        if (ev_done) begin
            st_d.done = 1'b1;
            if (ev_nack || (ev_derr != 4'h0)) st_d.err = 1'b1;
            if (ev_nack) st_d.nack = 1'b1;
            st_d.derr = st_d.derr | ev_derr;
        end
        if (ev_lbsy) st_d.lbsy = 1'b1;
        if (clr_all) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_word       = '0;
        status_word[0]    = st_q.done;
        status_word[1]    = st_q.err;
        status_word[2]    = st_q.lbsy;
        status_word[11:8] = st_q.derr;
        status_word[16]   = st_q.nack;
    end

    assign irq = gie & |({st_q.lbsy, st_q.err, st_q.done} & inte);
endmodule

// File: rtl/sbm_read_mux.sv
module sbm_read_mux
    import sbm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] w_ctrl,
    input  logic [WORD_W-1:0] w_clk,
    input  logic [WORD_W-1:0] w_inte,
    input  logic [WORD_W-1:0] w_stat,
    input  logic [WORD_W-1:0] w_ridx,
    input  logic [WORD_W-1:0] w_data,
    input  logic [WORD_W-1:0] w_line,
    input  logic [WORD_W-1:0] w_dmod,
    input  logic [WORD_W-1:0] w_cmd,
    input  logic [WORD_W-1:0] w_dadr,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if      (addr == ADDR_W'(OFS_CTRL)) rdata = w_ctrl;
        else if (addr == ADDR_W'(OFS_CLK))  rdata = w_clk;
        else if (addr == ADDR_W'(OFS_INTE)) rdata = w_inte;
        else if (addr == ADDR_W'(OFS_STAT)) rdata = w_stat;
        else if (addr == ADDR_W'(OFS_RIDX)) rdata = w_ridx;
        else if (addr == ADDR_W'(OFS_DATA)) rdata = w_data;
        else if (addr == ADDR_W'(OFS_LINE)) rdata = w_line;
        else if (addr == ADDR_W'(OFS_DMOD)) rdata = w_dmod;
        else if (addr == ADDR_W'(OFS_CMD))  rdata = w_cmd;
        else if (addr == ADDR_W'(OFS_DADR)) rdata = w_dadr;
    end
endmodule

// File: rtl/sbm_regfront.sv
module sbm_regfront
    import sbm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              eng_start,
    output logic              eng_abort,
    output logic [7:0]        eng_cmd,
    output logic [7:0]        eng_regaddr,
    output logic [31:0]       eng_wdata,
    output logic [7:0]        eng_rtaddr,
    output logic [15:0]       eng_hwaddr,
    input  logic              eng_done,
    input  logic [31:0]       eng_rdata,
    input  logic              eng_err_nack,
    input  logic [3:0]        eng_err_data,
    output logic              init_start,
    input  logic              init_done,
    output logic [7:0]        bus_div,
    output logic [2:0]        bus_sda_dly,
    output logic              scl_ovr_en,
    output logic              scl_ovr_val,
    output logic              sda_ovr_en,
    output logic              sda_ovr_val,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              irq
);
    front_t q, d;

    logic wr_ctrl, wr_clk, wr_inte, wr_stat, wr_ridx, wr_data;
    logic wr_line, wr_dmod, wr_cmd, wr_dadr;
    logic done_ev, lbsy_ev, clr_all;
    logic rd_is_read;
    logic [31:0] rd_masked;
    logic [31:0] status_word;

    assign wr_ctrl = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
    assign wr_clk  = host_wr && (host_addr == ADDR_W'(OFS_CLK));
    assign wr_inte = host_wr && (host_addr == ADDR_W'(OFS_INTE));
    assign wr_stat = host_wr && (host_addr == ADDR_W'(OFS_STAT));
    assign wr_ridx = host_wr && (host_addr == ADDR_W'(OFS_RIDX));
    assign wr_data = host_wr && (host_addr == ADDR_W'(OFS_DATA));
    assign wr_line = host_wr && (host_addr == ADDR_W'(OFS_LINE));
    assign wr_dmod = host_wr && (host_addr == ADDR_W'(OFS_DMOD));
    assign wr_cmd  = host_wr && (host_addr == ADDR_W'(OFS_CMD));
    assign wr_dadr = host_wr && (host_addr == ADDR_W'(OFS_DADR));

    sbm_width_mask #(.DW(WORD_W)) i_mask (
        .cmd     (q.cmd),
        .raw     (eng_rdata),
        .is_read (rd_is_read),
        .masked  (rd_masked)
    );

    always_comb begin
        d         = q;
        d.srst    = 1'b0;
        d.start_p = 1'b0;
        d.abort_p = 1'b0;
        d.init_p  = 1'b0;
        done_ev   = 1'b0;
        lbsy_ev   = 1'b0;
        clr_all   = 1'b0;

        if (q.busy && eng_done) begin
            d.busy  = 1'b0;
            done_ev = 1'b1;
            if (rd_is_read && !eng_err_nack && (eng_err_data == 4'h0))
                d.data = rd_masked;
        end
        if (q.dmod[DM_GO] && init_done) d.dmod[DM_GO] = 1'b0;

        if (wr_ctrl) begin
            d.gie = host_wdata[CB_GIE];
            if (host_wdata[CB_ABORT] && q.busy) begin
                d.busy    = 1'b0;
                d.abort_p = 1'b1;
                done_ev   = 1'b0;
            end else if (host_wdata[CB_START] && !q.busy && !q.dmod[DM_GO]) begin
                d.busy    = 1'b1;
                d.start_p = 1'b1;
            end
        end
        if (wr_clk)  d.clkctl = host_wdata[10:0];
        if (wr_inte) d.inte   = host_wdata[2:0];
        if (wr_line) d.line   = host_wdata[3:0];
        if (wr_dadr) d.dadr   = host_wdata[23:0];
        if (wr_dmod && !q.dmod[DM_GO]) begin
            d.dmod   = host_wdata;
            d.init_p = host_wdata[DM_GO];
        end

        if (wr_cmd || wr_ridx || wr_data) begin
            if (q.busy) lbsy_ev = 1'b1;
            else if (wr_cmd)  d.cmd  = host_wdata[7:0];
            else if (wr_ridx) d.ridx = host_wdata[7:0];
            else              d.data = host_wdata;
        end

        if (wr_ctrl && host_wdata[CB_SRST]) begin
            d       = '0;
            d.srst  = 1'b1;
            clr_all = 1'b1;
            done_ev = 1'b0;
            lbsy_ev = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sbm_status_unit i_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (clr_all),
        .wr_en       (wr_stat),
        .wdata       (host_wdata),
        .ev_done     (done_ev),
        .ev_nack     (eng_err_nack),
        .ev_derr     (eng_err_data),
        .ev_lbsy     (lbsy_ev),
        .inte        (q.inte),
        .gie         (q.gie),
        .status_word (status_word),
        .irq         (irq)
    );

    sbm_read_mux #(.ADDR_W(ADDR_W)) i_rmux (
        .addr   (host_addr),
        .w_ctrl ({24'h0, q.busy, 5'h0, q.gie, q.srst}),
        .w_clk  ({21'h0, q.clkctl}),
        .w_inte ({29'h0, q.inte}),
        .w_stat (status_word),
        .w_ridx ({24'h0, q.ridx}),
        .w_data (q.data),
        .w_line ({26'h0, scl_in, sda_in, q.line}),
        .w_dmod (q.dmod),
        .w_cmd  ({24'h0, q.cmd}),
        .w_dadr ({8'h0, q.dadr}),
        .rdata  (host_rdata)
    );

    assign eng_start   = q.start_p;
    assign eng_abort   = q.abort_p;
    assign eng_cmd     = q.cmd;
    assign eng_regaddr = q.ridx;
    assign eng_wdata   = q.data;
    assign eng_rtaddr  = q.dadr[23:16];
    assign eng_hwaddr  = q.dadr[15:0];
    assign init_start  = q.init_p;
    assign bus_div     = q.clkctl[7:0];
    assign bus_sda_dly = q.clkctl[10:8];
    assign scl_ovr_val = q.line[3];
    assign scl_ovr_en  = q.line[2];
    assign sda_ovr_val = q.line[1];
    assign sda_ovr_en  = q.line[0];

    logic        chk_busy;
    logic        chk_srst;
    logic        chk_gie;
    logic [7:0]  chk_cmd;
    assign chk_busy = q.busy;
    assign chk_srst = q.srst;
    assign chk_gie  = q.gie;
    assign chk_cmd  = q.cmd;
endmodule

// File: rtl/sbm_regfront_chk.sv
module sbm_regfront_chk
    import sbm_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic              eng_start,
    input logic              eng_abort,
    input logic              eng_done,
    input logic              irq,
    input logic              busy,
    input logic              srst,
    input logic              gie,
    input logic [7:0]        cmd,
    input logic [31:0]       status
);
    logic ctrl_wr, cmd_wr;
    assign ctrl_wr = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
    assign cmd_wr  = host_wr && (host_addr == ADDR_W'(OFS_CMD));

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);
    assert_done_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !ctrl_wr) |=> (!busy && status[0]));
    assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> (status[2] && $stable(cmd)));
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !busy);
    assert_srst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !srst);
endmodule

bind sbm_regfront sbm_regfront_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .eng_start (eng_start),
    .eng_abort (eng_abort),
    .eng_done  (eng_done),
    .irq       (irq),
    .busy      (chk_busy),
    .srst      (chk_srst),
    .gie       (chk_gie),
    .cmd       (chk_cmd),
    .status    (status_word)
);

// File: tb/test_sbm_regfront.sv
`timescale 1ns/1ps
module test_sbm_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        eng_start, eng_abort, init_start;
    logic [7:0]  eng_cmd, eng_regaddr, eng_rtaddr, bus_div;
    logic [31:0] eng_wdata;
    logic [15:0] eng_hwaddr;
    logic        eng_done = 1'b0;
    logic [31:0] eng_rdata = 32'h0;
    logic        eng_err_nack = 1'b0;
    logic [3:0]  eng_err_data = 4'h0;
    logic        init_done = 1'b0;
    logic [2:0]  bus_sda_dly;
    logic        scl_ovr_en, scl_ovr_val, sda_ovr_en, sda_ovr_val;
    logic        scl_in = 1'b1, sda_in = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    sbm_regfront i_sbm_regfront (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        host_addr = a;
        #0.1;
        v = host_rdata;
    endtask

    task automatic finish_xfer(input logic [31:0] r, input logic nk, input logic [3:0] de);
        @(negedge clk);
        eng_done = 1'b1; eng_rdata = r; eng_err_nack = nk; eng_err_data = de;
        @(posedge clk);
        @(negedge clk);
        eng_done = 1'b0; eng_err_nack = 1'b0; eng_err_data = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h1C, 8'h24, 8'h28, 8'h2C, 8'h30};
        logic [7:0] cmds [4] = '{8'h8B, 8'h9C, 8'hA6, 8'h4E};
        logic [31:0] expd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state (line control reads sensed levels in bits 5:4)
        for (int i = 0; i < 10; i++) begin
            rd(offs[i], rv);
            chk("R1 reset read", rv, (offs[i] == 8'h24) ? 32'h30 : 32'h0);
        end
        chk("R1 outputs", {31'h0, irq | eng_start | eng_abort | init_start}, 32'h0);

        // R12 configuration fields
        wr(8'h04, 32'h0000_05A3);
        chk("R12 bus_div", {24'h0, bus_div}, 32'hA3);
        chk("R12 sda_dly", {29'h0, bus_sda_dly}, 32'h5);
        wr(8'h30, 32'h002D_03A3);
        chk("R12 rtaddr", {24'h0, eng_rtaddr}, 32'h2D);
        chk("R12 hwaddr", {16'h0, eng_hwaddr}, 32'h03A3);

        // R11 line override and sensed levels
        wr(8'h24, 32'h0000_000A);
        chk("R11 overrides", {28'h0, scl_ovr_val, scl_ovr_en, sda_ovr_val, sda_ovr_en}, 32'hA);
        for (int s = 0; s < 4; s++) begin
            scl_in = s[1]; sda_in = s[0];
            rd(8'h24, rv);
            chk("R11 line readback", rv, {26'h0, s[1:0], 4'hA});
        end

        // R2 R3 R4 R5 R6 over all command kinds
        for (int c = 0; c < 4; c++) begin
            wr(8'h10, 32'h0000_0012);
            wr(8'h1C, 32'h1122_3344);
            wr(8'h2C, {24'h0, cmds[c]});
            wr(8'h00, 32'h80);
            chk("R2 start pulse", {31'h0, eng_start}, 32'h1);
            rd(8'h00, rv);
            chk("R2 busy bit", rv, 32'h80);
            @(negedge clk);
            chk("R2 pulse ends", {31'h0, eng_start}, 32'h0);
            wr(8'h2C, 32'h0000_0000);
            rd(8'h2C, rv);
            chk("R5 cmd ignored", rv, {24'h0, cmds[c]});
            rd(8'h0C, rv);
            chk("R5 load busy", rv, 32'h4);
            finish_xfer(32'hCAFE_F00D, 1'b0, 4'h0);
            rd(8'h00, rv);
            chk("R2 busy cleared", rv, 32'h0);
            rd(8'h0C, rv);
            chk("R3 done", rv, 32'h5);
            case (c)
                0: expd = 32'h0000_000D;
                1: expd = 32'h0000_F00D;
                2: expd = 32'hCAFE_F00D;
                default: expd = 32'h1122_3344;
            endcase
            rd(8'h1C, rv);
            chk("R4 masked data", rv, expd);
            wr(8'h0C, 32'h0000_0004);
            rd(8'h0C, rv);
            chk("R6 clear lbsy only", rv, 32'h1);
            wr(8'h0C, 32'h0000_0001);
            rd(8'h0C, rv);
            chk("R6 clear done", rv, 32'h0);
        end

        // R3 R4 error outcomes: data register untouched on failed read
        wr(8'h1C, 32'h5555_AAAA);
        wr(8'h2C, 32'h8B);
        wr(8'h00, 32'h80);
        finish_xfer(32'h1234_5678, 1'b1, 4'h0);
        rd(8'h0C, rv);
        chk("R3 nack status", rv, 32'h0001_0003);
        rd(8'h1C, rv);
        chk("R4 no update on error", rv, 32'h5555_AAAA);
        wr(8'h0C, 32'h0000_0002);
        rd(8'h0C, rv);
        chk("R6 partial clear", rv, 32'h0001_0001);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h00, 32'h80);
        finish_xfer(32'h0, 1'b0, 4'hA);
        rd(8'h0C, rv);
        chk("R3 data error status", rv, 32'h0000_0A03);

        // R7 irq sweep with done, err, lbsy set
        wr(8'h00, 32'h80);
        wr(8'h1C, 32'h0);
        finish_xfer(32'h0, 1'b1, 4'h0);
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 8; m++) begin
                wr(8'h08, m);
                wr(8'h00, g << 1);
                chk("R7 irq sweep", {31'h0, irq}, {31'h0, (g == 1) && (m != 0)});
            end
        end
        wr(8'h0C, 32'hFFFF_FFFF);
        for (int b = 0; b < 3; b++) begin
            wr(8'h08, 32'h1 << b);
            wr(8'h00, 32'h80 | 32'h2);
            if (b == 2) wr(8'h1C, 32'h0);
            finish_xfer(32'h0, b == 1, 4'h0);
            chk("R7 single source", {31'h0, irq}, 32'h1);
            wr(8'h0C, 32'h1 << b);
            chk("R7 cleared source", {31'h0, irq}, 32'h0);
            wr(8'h0C, 32'hFFFF_FFFF);
        end

        // R8 abort
        wr(8'h00, 32'h80);
        wr(8'h00, 32'h40);
        chk("R8 abort pulse", {31'h0, eng_abort}, 32'h1);
        rd(8'h00, rv);
        chk("R8 busy cleared", rv, 32'h0);
        rd(8'h0C, rv);
        chk("R8 no status", rv, 32'h0);
        @(negedge clk);
        chk("R8 pulse ends", {31'h0, eng_abort}, 32'h0);

        // R10 device init
        wr(8'h28, 32'h807C_3E00);
        chk("R10 init pulse", {31'h0, init_start}, 32'h1);
        rd(8'h28, rv);
        chk("R10 go held", rv, 32'h807C_3E00);
        repeat (3) @(negedge clk);
        rd(8'h28, rv);
        chk("R10 still held", rv, 32'h807C_3E00);
        @(negedge clk); init_done = 1'b1;
        @(negedge clk); init_done = 1'b0;
        rd(8'h28, rv);
        chk("R10 go cleared", rv, 32'h007C_3E00);

        // R9 soft reset
        wr(8'h08, 32'h7);
        wr(8'h00, 32'h80);
        wr(8'h00, 32'h1);
        rd(8'h00, rv);
        chk("R9 srst visible", rv, 32'h1);
        @(negedge clk);
        rd(8'h00, rv);
        chk("R9 srst self clears", rv, 32'h0);
        rd(8'h04, rv);
        chk("R9 clock ctl reset", rv, 32'h0);
        rd(8'h08, rv);
        chk("R9 inte reset", rv, 32'h0);
        rd(8'h0C, rv);
        chk("R9 status reset", rv, 32'h0);
        rd(8'h28, rv);
        chk("R9 devmode reset", rv, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule